// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Drift Trim

This block keeps wall-clock time (seconds, minutes, hours, day of month, month and a two-digit year counted from 2000) and advances it on a one-pulse-per-second tick supplied from outside. Software sees a small byte-wide register file in which every time and alarm field is BCD encoded. The hour field can be presented and written either in 24-hour form or in 12-hour form with a PM flag.

A control byte starts and stops counting, arms the alarm, picks the hour presentation and selects how often a recurring timer pulse is raised: every second, at each new minute, at each new hour or at each new day. A second pulse fires when the running time reaches the programmed alarm time. Both pulses are one clock wide and are meant for an interrupt controller.

Crystal drift is trimmed by a signed 16-bit value in units of 1/32768 s. Once per hour of counted ticks that value is added to a fractional phase accumulator; when the phase reaches a whole second the clock takes one extra step, and when it falls to minus one second the next tick is swallowed.

Top module: `rtc_bcd_top`

## Requirements
- R1: After reset the control byte reads 0x00, the time reads 00:00:00 on day 01, month 01, year 00, the alarm holds the same values, the trim value is zero, and neither pulse output is high.
- R2: The register map is: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 to 12 the alarm fields in that same order, 13 trim high byte, 14 trim low byte; other addresses read 0. Control bit 0 runs the clock, bit 1 arms the alarm, bit 2 selects 12-hour form, bits 4:3 pick the timer period; only bits 4:0 are stored and bits 7:5 read 0.
- R3: While running, each tick advances the time by one second; seconds and minutes wrap 59 to 0, hours 23 to 0, the day wraps after the last day of the month (30 for April, June, September, November; 31 for the others; February 29 when the year field is a multiple of 4, else 28), the month wraps 12 to 1 and the year 99 to 0.
- R4: While bit 0 of control is clear, ticks leave the time unchanged and no timer or alarm pulse is raised.
- R5: The timer pulse appears for one clock in the cycle after an advancing tick: period code 0 on every step, 1 when the new seconds are 0, 2 when the new seconds and minutes are 0, 3 when the new seconds, minutes and hours are 0.
- R6: In 12-hour form the hour field reads BCD 12 for hour 0, 1 to 11 for hours 1 to 11, and 12 then 1 to 11 with bit 7 set for hours 12 to 23; a write takes BCD hours from bits 5:0 (0 or above 12 taken as 12) and the PM flag from bit 7. In 24-hour form bits 5:0 hold BCD 0 to 23.
- R7: Seconds and minutes writes use only bits 6:0; a month written as 0 is stored as 1; the year is a two-digit BCD offset from 2000; out-of-range values clamp to the field maximum.
- R8: With the alarm armed and the clock running, a one-clock alarm pulse is raised when a step makes all six time fields equal the alarm fields; with the alarm disarmed no alarm pulse is raised.
- R9: Every COMP_PERIOD running ticks the signed trim value is added to a phase; reaching +32768 causes one extra one-second step in the following clock cycle, reaching -32768 causes the next tick to be ignored; the phase keeps the remainder.
- R10: The first trim is applied on the COMP_FIRST-th running tick after reset (defaults 1800 and 3600).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| timerEvt | output | 1 | Recurring timer pulse |
| alarmEvt | output | 1 | Alarm match pulse |

## Verification
The calendar carry chain is driven from starting times chosen to stop at each wrap point: a plain count, a full year wrap, February end in a leap and a non-leap year, a 30-day and a 31-day month, and noon in 24-hour form, so a wrong month length or a missing carry shows up as a distinct field error. The timer period codes are tried from starting points just before a minute, hour and day boundary and from one that crosses a minute but not an hour, which separates the codes from each other. The trim is tried with a positive half second, which must take two applications before the extra step, and with a negative full second, whose swallowed tick pins down the tick on which the first application lands.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [4:0] day;
    logic [3:0] mon;
    logic [6:0] year;
  } rtcTime_t;

  typedef struct packed {
    logic       run;
    logic       alarmOn;
    logic       mode12;
    logic [1:0] period;
  } rtcCtrl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;    // step the time by one second
    logic trimApply;  // trim added to phase this cycle
  } rtcStrobe_t;

  localparam int REG_CTRL  = 0;
  localparam int REG_SEC   = 1;
  localparam int REG_MIN   = 2;
  localparam int REG_HOUR  = 3;
  localparam int REG_DAY   = 4;
  localparam int REG_MON   = 5;
  localparam int REG_YEAR  = 6;
  localparam int REG_ASEC  = 7;
  localparam int REG_AMIN  = 8;
  localparam int REG_AHOUR = 9;
  localparam int REG_ADAY  = 10;
  localparam int REG_AMON  = 11;
  localparam int REG_AYEAR = 12;
  localparam int REG_TRMH  = 13;
  localparam int REG_TRML  = 14;

  function automatic logic [7:0] bcdToBin(input logic [7:0] v);
    return 8'(v[7:4] * 4'd10) + 8'(v[3:0]);
  endfunction

  function automatic logic [7:0] binToBcd(input logic [6:0] v);
    logic [6:0] tens;
    tens = v / 7'd10;
    return {tens[3:0], 4'(v - tens * 7'd10)};
  endfunction

  function automatic logic [7:0] clampTo(input logic [7:0] v, input logic [7:0] lo,
                                         input logic [7:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [4:0] daysInMonth(input logic [3:0] mon, input logic [6:0] year);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  // Hour field decode for a write, both presentations
  function automatic logic [4:0] hourFromReg(input logic [7:0] v, input logic mode12);
    logic [7:0] h;
    h = bcdToBin({2'b00, v[5:0]});
    if (!mode12) return 5'(clampTo(h, 8'd0, 8'd23));
    if (h == 8'd0 || h > 8'd12) h = 8'd12;
    if (h == 8'd12) return v[7] ? 5'd12 : 5'd0;
    return v[7] ? 5'(h + 8'd12) : 5'(h);
  endfunction

  function automatic logic [7:0] hourToReg(input logic [4:0] h, input logic mode12);
    logic [4:0] hh;
    if (!mode12) return binToBcd({2'b00, h});
    hh = (h >= 5'd12) ? h - 5'd12 : h;
    if (hh == 5'd0) hh = 5'd12;
    return {h >= 5'd12, binToBcd({2'b00, hh})[6:0]};
  endfunction

endpackage

// File: rtl/rtc_bcd_control.sv
module rtc_bcd_control
  import rtc_bcd_pkg::*;
#(
  parameter int COMP_FIRST  = 1800,
  parameter int COMP_PERIOD = 3600,
  parameter int FRAC_BITS   = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        run,
  input  logic [15:0] trim,
  output rtcStrobe_t  strobe
);

  localparam int CNT_MAX = (COMP_FIRST > COMP_PERIOD) ? COMP_FIRST : COMP_PERIOD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PH_W    = FRAC_BITS + 3;
  localparam logic signed [PH_W-1:0] ONE_SEC = PH_W'(1) <<< FRAC_BITS;

  logic [CNT_W-1:0]       tickCnt;
  logic signed [PH_W-1:0] phase;
  logic signed [PH_W-1:0] phaseSum;
  logic                   extraPend;
  logic                   skipPend;
  logic                   tickRun;
  logic                   trimNow;

  assign tickRun  = secTick && run;
  assign trimNow  = tickRun && (tickCnt == CNT_W'(1));
  assign phaseSum = phase + PH_W'($signed(trim));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt   <= CNT_W'(COMP_FIRST);
      phase     <= '0;
      extraPend <= 1'b0;
      skipPend  <= 1'b0;
    end else begin
      if (run && extraPend) extraPend <= 1'b0;
      if (tickRun) begin
        if (skipPend) skipPend <= 1'b0;
        if (trimNow) tickCnt <= CNT_W'(COMP_PERIOD);
        else         tickCnt <= tickCnt - CNT_W'(1);
      end
      if (trimNow) begin
        if (phaseSum >= ONE_SEC) begin
          phase     <= phaseSum - ONE_SEC;
          extraPend <= 1'b1;
        end else if (phaseSum <= -ONE_SEC) begin
          phase    <= phaseSum + ONE_SEC;
          skipPend <= 1'b1;
        end else begin
          phase <= phaseSum;
        end
      end
    end
  end

  always_comb begin
    strobe.advance   = (tickRun && !skipPend) || (run && extraPend);
    strobe.trimApply = trimNow;
  end

endmodule

// File: rtl/rtc_bcd_datapath.sv
module rtc_bcd_datapath
  import rtc_bcd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  rtcStrobe_t        strobe,
  output rtcCtrl_t          ctrlNow,
  output logic [15:0]       trim,
  output rtcTime_t          timeNow,
  output logic              timerEvt,
  output logic              alarmEvt
);

  localparam rtcTime_t TIME_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                      day: 5'd1, mon: 4'd1, year: 7'd0};

  rtcTime_t curTime, almTime, nextTime, curWr, almWr;
  logic     periodHit;
  logic     wrCurField, wrAlmField;
  int       regIdx;

  assign regIdx = int'(addr);

  // Calendar carry chain
  always_comb begin
    nextTime = curTime;
    if (curTime.sec >= 6'd59) begin
      nextTime.sec = '0;
      if (curTime.min >= 6'd59) begin
        nextTime.min = '0;
        if (curTime.hour >= 5'd23) begin
          nextTime.hour = '0;
          if (curTime.day >= daysInMonth(curTime.mon, curTime.year)) begin
            nextTime.day = 5'd1;
            if (curTime.mon >= 4'd12) begin
              nextTime.mon  = 4'd1;
              nextTime.year = (curTime.year >= 7'd99) ? 7'd0 : curTime.year + 7'd1;
            end else begin
              nextTime.mon = curTime.mon + 4'd1;
            end
          end else begin
            nextTime.day = curTime.day + 5'd1;
          end
        end else begin
          nextTime.hour = curTime.hour + 5'd1;
        end
      end else begin
        nextTime.min = curTime.min + 6'd1;
      end
    end else begin
      nextTime.sec = curTime.sec + 6'd1;
    end
  end

  always_comb begin
    case (ctrlNow.period)
      2'd0:    periodHit = 1'b1;
      2'd1:    periodHit = (nextTime.sec == '0);
      2'd2:    periodHit = (nextTime.sec == '0) && (nextTime.min == '0);
      default: periodHit = (nextTime.sec == '0) && (nextTime.min == '0) &&
                           (nextTime.hour == '0);
    endcase
  end

  // Decoded field writes for the running time and the alarm set
  function automatic rtcTime_t applyField(input rtcTime_t t, input int idx,
                                          input logic [7:0] v, input logic mode12);
    rtcTime_t r;
    r = t;
    case (idx)
      0: r.sec  = 6'(clampTo(bcdToBin({1'b0, v[6:0]}), 8'd0, 8'd59));
      1: r.min  = 6'(clampTo(bcdToBin({1'b0, v[6:0]}), 8'd0, 8'd59));
      2: r.hour = hourFromReg(v, mode12);
      3: r.day  = 5'(clampTo(bcdToBin(v), 8'd1, 8'd31));
      4: r.mon  = 4'(clampTo(bcdToBin(v), 8'd1, 8'd12));
      default: r.year = 7'(clampTo(bcdToBin(v), 8'd0, 8'd99));
    endcase
    return r;
  endfunction

  assign wrCurField = wrEn && regIdx >= REG_SEC  && regIdx <= REG_YEAR;
  assign wrAlmField = wrEn && regIdx >= REG_ASEC && regIdx <= REG_AYEAR;
  assign curWr = applyField(curTime, regIdx - REG_SEC,  wrData, ctrlNow.mode12);
  assign almWr = applyField(almTime, regIdx - REG_ASEC, wrData, ctrlNow.mode12);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime  <= TIME_RESET;
      almTime  <= TIME_RESET;
      ctrlNow  <= '0;
      trim     <= '0;
      timerEvt <= 1'b0;
      alarmEvt <= 1'b0;
    end else begin
      timerEvt <= strobe.advance && periodHit;
      alarmEvt <= strobe.advance && ctrlNow.alarmOn && (nextTime == almTime);
      if (wrCurField)          curTime <= curWr;
      else if (strobe.advance) curTime <= nextTime;
      if (wrAlmField) almTime <= almWr;
      if (wrEn) begin
        case (regIdx)
          REG_CTRL: ctrlNow <= '{run: wrData[0], alarmOn: wrData[1], mode12: wrData[2],
                                 period: wrData[4:3]};
          REG_TRMH: trim[15:8] <= wrData;
          REG_TRML: trim[7:0]  <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regIdx)
      REG_CTRL:  rdData = {3'b000, ctrlNow.period, ctrlNow.mode12, ctrlNow.alarmOn,
                           ctrlNow.run};
      REG_SEC:   rdData = binToBcd({1'b0, curTime.sec});
      REG_MIN:   rdData = binToBcd({1'b0, curTime.min});
      REG_HOUR:  rdData = hourToReg(curTime.hour, ctrlNow.mode12);
      REG_DAY:   rdData = binToBcd({2'b00, curTime.day});
      REG_MON:   rdData = binToBcd({3'b000, curTime.mon});
      REG_YEAR:  rdData = binToBcd(curTime.year);
      REG_ASEC:  rdData = binToBcd({1'b0, almTime.sec});
      REG_AMIN:  rdData = binToBcd({1'b0, almTime.min});
      REG_AHOUR: rdData = hourToReg(almTime.hour, ctrlNow.mode12);
      REG_ADAY:  rdData = binToBcd({2'b00, almTime.day});
      REG_AMON:  rdData = binToBcd({3'b000, almTime.mon});
      REG_AYEAR: rdData = binToBcd(almTime.year);
      REG_TRMH:  rdData = trim[15:8];
      REG_TRML:  rdData = trim[7:0];
      default:   rdData = 8'h00;
    endcase
  end

  assign timeNow = curTime;

endmodule

// File: rtl/rtc_bcd_top.sv
module rtc_bcd_top
  import rtc_bcd_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int COMP_FIRST  = 1800,
  parameter int COMP_PERIOD = 3600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              timerEvt,
  output logic              alarmEvt
);

  rtcStrobe_t  strobe;
  rtcCtrl_t    ctrlNow;
  rtcTime_t    timeNow;
  logic [15:0] trim;

  rtc_bcd_control #(
    .COMP_FIRST (COMP_FIRST),
    .COMP_PERIOD(COMP_PERIOD),
    .FRAC_BITS  (15)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .secTick(secTick),
    .run    (ctrlNow.run),
    .trim   (trim),
    .strobe (strobe)
  );

  rtc_bcd_datapath #(
    .ADDR_W(ADDR_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .strobe  (strobe),
    .ctrlNow (ctrlNow),
    .trim    (trim),
    .timeNow (timeNow),
    .timerEvt(timerEvt),
    .alarmEvt(alarmEvt)
  );

endmodule

// File: rtl/rtc_bcd_checker.sv
module rtc_bcd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       run,
  input logic       alarmOn,
  input logic [1:0] period,
  input logic       wrEn,
  input logic [5:0] secBin,
  input logic [5:0] minBin,
  input logic [4:0] hourBin,
  input logic [3:0] monBin,
  input logic       timerEvt,
  input logic       alarmEvt
);

  assert_quiet_when_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(run) |-> (!timerEvt && !alarmEvt));

  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(run) && !$past(wrEn)) |-> $stable(secBin));

  assert_fields_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (secBin < 6'd60) && (minBin < 6'd60) && (hourBin < 5'd24) &&
    (monBin >= 4'd1) && (monBin <= 4'd12));

  assert_minute_event_on_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timerEvt && $past(period) == 2'd1) |-> (secBin == 6'd0));

  assert_alarm_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |-> $past(alarmOn));

  assert_alarm_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> !alarmEvt);

endmodule

bind rtc_bcd_top rtc_bcd_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .run     (ctrlNow.run),
  .alarmOn (ctrlNow.alarmOn),
  .period  (ctrlNow.period),
  .wrEn    (wrEn),
  .secBin  (timeNow.sec),
  .minBin  (timeNow.min),
  .hourBin (timeNow.hour),
  .monBin  (timeNow.mon),
  .timerEvt(timerEvt),
  .alarmEvt(alarmEvt)
);

// File: tb/rtc_bcd_top_test.sv
`timescale 1ns/1ps
module rtc_bcd_top_test;

  localparam int AW = 5;
  localparam int A_CTRL = 0, A_SEC = 1, A_MIN = 2, A_HOUR = 3, A_DAY = 4, A_MON = 5,
                 A_YEAR = 6, A_ASEC = 7, A_AMIN = 8, A_AHOUR = 9, A_ADAY = 10,
                 A_AMON = 11, A_AYEAR = 12, A_TRMH = 13, A_TRML = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          secTick = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic          timerEvt, alarmEvt;

  int checks = 0;
  int errors = 0;
  int tmrCnt = 0;
  int almCnt = 0;
  int cycles = 0;

  rtc_bcd_top #(.ADDR_W(AW), .COMP_FIRST(4), .COMP_PERIOD(6)) uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timerEvt(timerEvt), .alarmEvt(alarmEvt));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (timerEvt) tmrCnt <= tmrCnt + 1;
    if (alarmEvt) almCnt <= almCnt + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // start time (BCD s,m,h,d,mo,y), ticks, expected (BCD s,m,h,d,mo,y)
  localparam logic [103:0] VEC [7] = '{
    {8'h00,8'h00,8'h00,8'h01,8'h01,8'h00, 8'd5, 8'h05,8'h00,8'h00,8'h01,8'h01,8'h00},
    {8'h58,8'h59,8'h23,8'h31,8'h12,8'h99, 8'd3, 8'h01,8'h00,8'h00,8'h01,8'h01,8'h00},
    {8'h59,8'h59,8'h23,8'h28,8'h02,8'h01, 8'd1, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h01},
    {8'h59,8'h59,8'h23,8'h28,8'h02,8'h04, 8'd1, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h04},
    {8'h59,8'h59,8'h23,8'h30,8'h04,8'h10, 8'd1, 8'h00,8'h00,8'h00,8'h01,8'h05,8'h10},
    {8'h59,8'h59,8'h23,8'h30,8'h01,8'h10, 8'd1, 8'h00,8'h00,8'h00,8'h31,8'h01,8'h10},
    {8'h59,8'h59,8'h11,8'h15,8'h06,8'h20, 8'd2, 8'h01,8'h00,8'h12,8'h15,8'h06,8'h20}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    regWrite(A_SEC, s); regWrite(A_MIN, m); regWrite(A_HOUR, h);
    regWrite(A_DAY, d); regWrite(A_MON, mo); regWrite(A_YEAR, y);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    logic [7:0] r;
    int t0;
    doReset();

    // R1 reset state
    regRead(A_CTRL, r); check("R1 ctrl", r, 8'h00);
    regRead(A_SEC, r);  check("R1 sec", r, 8'h00);
    regRead(A_HOUR, r); check("R1 hour", r, 8'h00);
    regRead(A_DAY, r);  check("R1 day", r, 8'h01);
    regRead(A_MON, r);  check("R1 month", r, 8'h01);
    regRead(A_AMON, r); check("R1 alarm month", r, 8'h01);
    regRead(A_TRML, r); check("R1 trim", r, 8'h00);
    check("R1 pulses", {30'd0, timerEvt, alarmEvt}, 0);

    // R2 control width and unmapped address
    regWrite(A_CTRL, 8'hFE); regRead(A_CTRL, r); check("R2 ctrl mask", r, 8'h1E);
    regRead(20, r); check("R2 unmapped", r, 8'h00);
    regWrite(A_CTRL, 8'h00);

    // R4 stopped clock ignores ticks
    setTime(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h02);
    t0 = tmrCnt;
    ticks(3);
    regRead(A_SEC, r); check("R4 sec held", r, 8'h10);
    check("R4 no pulses", tmrCnt - t0, 0);

    // R3 table of calendar cases
    foreach (VEC[k]) begin
      regWrite(A_CTRL, 8'h00);
      setTime(VEC[k][103:96], VEC[k][95:88], VEC[k][87:80], VEC[k][79:72],
              VEC[k][71:64], VEC[k][63:56]);
      regWrite(A_CTRL, 8'h01);
      ticks(int'(VEC[k][55:48]));
      for (int f = 0; f < 6; f++) begin
        regRead(A_SEC + f, r);
        check($sformatf("R3 row %0d field %0d", k, f), r, VEC[k][47-8*f -: 8]);
      end
    end

    // R5 timer periods
    regWrite(A_CTRL, 8'h00); setTime(8'h20, 8'h10, 8'h05, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h01); t0 = tmrCnt; ticks(3);
    check("R5 every second", tmrCnt - t0, 3);
    regWrite(A_CTRL, 8'h00); setTime(8'h58, 8'h10, 8'h05, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h09); t0 = tmrCnt; ticks(3);
    check("R5 minute", tmrCnt - t0, 1);
    regWrite(A_CTRL, 8'h00); setTime(8'h58, 8'h10, 8'h05, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h11); t0 = tmrCnt; ticks(3);
    check("R5 hour not on minute", tmrCnt - t0, 0);
    regWrite(A_CTRL, 8'h00); setTime(8'h58, 8'h59, 8'h05, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h11); t0 = tmrCnt; ticks(3);
    check("R5 hour", tmrCnt - t0, 1);
    regWrite(A_CTRL, 8'h00); setTime(8'h58, 8'h59, 8'h22, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h19); t0 = tmrCnt; ticks(3);
    check("R5 day not on hour", tmrCnt - t0, 0);
    regWrite(A_CTRL, 8'h00); setTime(8'h58, 8'h59, 8'h23, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h19); t0 = tmrCnt; ticks(3);
    check("R5 day", tmrCnt - t0, 1);

    // R6 12-hour form
    regWrite(A_CTRL, 8'h04); regWrite(A_HOUR, 8'h87);
    regRead(A_HOUR, r); check("R6 read 7 PM", r, 8'h87);
    regWrite(A_CTRL, 8'h00); regRead(A_HOUR, r); check("R6 7 PM as 24h", r, 8'h19);
    regWrite(A_HOUR, 8'h00); regWrite(A_CTRL, 8'h04);
    regRead(A_HOUR, r); check("R6 midnight reads 12 AM", r, 8'h12);
    regWrite(A_HOUR, 8'h92); regWrite(A_CTRL, 8'h00);
    regRead(A_HOUR, r); check("R6 12 PM as 24h", r, 8'h12);
    regWrite(A_CTRL, 8'h04); regWrite(A_AHOUR, 8'h12); regWrite(A_CTRL, 8'h00);
    regRead(A_AHOUR, r); check("R6 alarm 12 AM as 24h", r, 8'h00);

    // R7 field encodings
    regWrite(A_SEC, 8'hD9); regRead(A_SEC, r); check("R7 sec bits 6:0", r, 8'h59);
    regWrite(A_MON, 8'h00); regRead(A_MON, r); check("R7 month zero", r, 8'h01);
    regWrite(A_YEAR, 8'h47); regRead(A_YEAR, r); check("R7 year", r, 8'h47);

    // R8 alarm
    regWrite(A_CTRL, 8'h00);
    regWrite(A_ASEC, 8'h05); regWrite(A_AMIN, 8'h00); regWrite(A_AHOUR, 8'h00);
    regWrite(A_ADAY, 8'h01); regWrite(A_AMON, 8'h01); regWrite(A_AYEAR, 8'h00);
    setTime(8'h03, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h03); t0 = almCnt; ticks(3);
    check("R8 armed match", almCnt - t0, 1);
    regWrite(A_CTRL, 8'h00); setTime(8'h03, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    regWrite(A_CTRL, 8'h01); t0 = almCnt; ticks(3);
    check("R8 disarmed", almCnt - t0, 0);

    // R10 first trim on tick 4: -1 s swallows tick 5
    doReset();
    regWrite(A_TRMH, 8'h80); regWrite(A_TRML, 8'h00);
    regWrite(A_CTRL, 8'h01); ticks(5);
    regRead(A_SEC, r); check("R10 first trim swallows a tick", r, 8'h04);
    ticks(1); regRead(A_SEC, r); check("R10 counting resumes", r, 8'h05);

    // R9 +0.5 s per period: extra step at the second application (tick 10)
    doReset();
    regWrite(A_TRMH, 8'h40); regWrite(A_TRML, 8'h00);
    regWrite(A_CTRL, 8'h01); ticks(9);
    regRead(A_SEC, r); check("R9 no extra yet", r, 8'h09);
    ticks(1); regRead(A_SEC, r); check("R9 extra step", r, 8'h11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule